// File: doc/BRIEF.md
# Programmable Power-On Reset Sequencer

This block produces an active-low reset for a microcontroller from a supply-health flag. The flag comes from an external undervoltage comparator and is already synchronised to the clock. After power-up, and after every confirmed undervoltage event, the reset output stays low until a release delay has run out in full. A static strap input picks one of two delay lengths. The block measures all time by counting a 1 µs tick input. Every count length is a parameter.

An undervoltage flag must stay high for a blanking interval before it counts, so short glitches are ignored. Once the flag is confirmed, reset asserts on the next clock, well inside the required reaction time. When the enable input is low, the supply is treated as out of range and reset is held. A complementary `in_reset` level is provided for a neighbouring watchdog.

Top module: `por_reset_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the cycle after it, `ro_n` is 0.
- R2: `in_reset` is always the inverse of `ro_n`.
- R3: When `enable` is low at a clock edge, `ro_n` is 0 after that edge. It stays 0 for as long as `enable` stays low, whatever `uv_flag` and `tick_us` do.
- R4: With `delay_fast` = 0 when the delay starts, `ro_n` rises at the edge of the SLOW_TICKS-th tick. Ticks are counted from the clock after the fault clears (default 16500 ticks, 16.5 ms).
- R5: With `delay_fast` = 1 when the delay starts, `ro_n` rises at the edge of the FAST_TICKS-th tick counted (default 8500 ticks, 8.5 ms).
- R6: `delay_fast` is sampled only on the clock where the delay count starts. Changing it during the count has no effect on the delay length.
- R7: A `uv_flag` pulse that spans fewer than BLANK_TICKS ticks (default 7) leaves `ro_n` high.
- R8: When `uv_flag` stays high for BLANK_TICKS consecutive ticks, `ro_n` falls on the next clock. This is inside 10 µs at the default settings.
- R9: A confirmed undervoltage during the delay count cancels the count. The full delay restarts once the fault clears.
- R10: Once released, `ro_n` stays high until a fault (disable or confirmed undervoltage) occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| enable | input | 1 | Block enable; low forces reset |
| uv_flag | input | 1 | Synchronised undervoltage flag, high = supply low |
| delay_fast | input | 1 | Strap: 1 selects the short release delay |
| ro_n | output | 1 | Active-low reset output, registered |
| in_reset | output | 1 | High while reset is asserted, for the watchdog |

## Verification
The assertions assume two things about the inputs. First, `tick_us` is a single-cycle pulse with idle cycles between pulses. Second, `uv_flag` and `enable` are already synchronous, so a change counts from the edge that samples it. The stimulus raises the tick for one cycle with one low cycle after it. It changes `enable`, `uv_flag` and `delay_fast` only on falling clock edges while the tick is low. After each fault clears, the stimulus leaves two quiet cycles, so the start of the count is known exactly. Random glitch lengths are drawn below the blanking count. Random strap values are drawn per release, and each expected delay comes from a bench function.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/por_uv_filter.sv
module por_uv_filter #(
  parameter int unsigned BLANK_TICKS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic uv_flag,
  output logic uv_conf
);
  localparam int unsigned BW = por_pkg::cnt_width(BLANK_TICKS);

  logic [BW-1:0] blank_cnt;

  assign uv_conf = (blank_cnt == BW'(BLANK_TICKS));

  always_ff @(posedge clk) begin
    if (rst || !uv_flag) begin
      blank_cnt <= '0;
    end else if (tick_us && !uv_conf) begin
      blank_cnt <= blank_cnt + 1'b1;
    end
  end

  // R7: confirmation only appears on a tick while the flag is high
  p_confirm_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_conf) |-> ($past(tick_us) && $past(uv_flag)));

  // R7: counter never passes the blanking limit
  p_blank_bound_r7: assert property (@(posedge clk) disable iff (rst)
    blank_cnt <= BW'(BLANK_TICKS));
endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter int unsigned SLOW_TICKS = 16500,
  parameter int unsigned FAST_TICKS = 8500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic tick_us,
  input  logic fast_sel,
  output logic done
);
  localparam int unsigned MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int unsigned CW   = por_pkg::cnt_width(MAXT);

  logic [CW-1:0] dly_cnt;
  logic          sel_q;
  logic [CW-1:0] last_val;

  assign last_val = sel_q ? CW'(FAST_TICKS - 1) : CW'(SLOW_TICKS - 1);
  assign done     = run && tick_us && (dly_cnt == last_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_cnt <= '0;
      sel_q   <= 1'b0;
    end else if (start) begin
      dly_cnt <= '0;
      sel_q   <= fast_sel;
    end else if (run && tick_us && !done) begin
      dly_cnt <= dly_cnt + 1'b1;
    end
  end

  // R6: the selected delay is frozen while counting
  p_sel_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(start) && !$past(rst)) |-> $stable(sel_q));

  // R4: the count never runs past the selected limit
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (dly_cnt <= last_val));
endmodule

// File: rtl/por_reset_seq.sv
module por_reset_seq #(
  parameter int unsigned BLANK_TICKS = 7,
  parameter int unsigned SLOW_TICKS  = 16500,
  parameter int unsigned FAST_TICKS  = 8500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic enable,
  input  logic uv_flag,
  input  logic delay_fast,
  output logic ro_n,
  output logic in_reset
);
  import por_pkg::*;

  seq_state_t state_q, state_d;
  logic       uv_conf;
  logic       fault;
  logic       start;
  logic       run;
  logic       done;
  logic       ro_n_q;

  por_uv_filter #(.BLANK_TICKS(BLANK_TICKS)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .tick_us (tick_us),
    .uv_flag (uv_flag),
    .uv_conf (uv_conf)
  );

  assign fault = !enable || uv_conf;
  assign start = (state_q == ST_HOLD) && !fault;
  assign run   = (state_q == ST_COUNT) && !fault;

  por_delay_timer #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .run      (run),
    .tick_us  (tick_us),
    .fast_sel (delay_fast),
    .done     (done)
  );

  always_comb begin
    state_d = state_q;
    if (fault) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:  state_d = ST_COUNT;
        ST_COUNT: state_d = done ? ST_RUN : ST_COUNT;
        ST_RUN:   state_d = ST_RUN;
        default:  state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD;
      ro_n_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ro_n_q  <= (state_d == ST_RUN);
    end
  end

  assign ro_n     = ro_n_q;
  assign in_reset = !ro_n_q;

  // R3: disable forces reset on the following clock
  p_disable_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !ro_n);

  // R8: a confirmed undervoltage drives reset on the next clock
  p_uv_reacts_r8: assert property (@(posedge clk) disable iff (rst)
    uv_conf |=> !ro_n);

  // R4: release happens only on a tick edge
  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ro_n) |-> $past(tick_us));

  // R10: once released, reset returns only through a fault
  p_stays_released_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(ro_n) |-> ($past(!enable) || $past(uv_conf)));

  // R2: status output mirrors the reset pin
  always_comb begin
    p_status_mirror_r2: assert (in_reset == !ro_n);
  end
endmodule

// File: tb/por_reset_seq_bench.sv
module por_reset_seq_bench;
  localparam int unsigned BLANK = 7;
  localparam int unsigned SLOW  = 40;
  localparam int unsigned FAST  = 20;

  logic clk = 1'b0;
  logic rst, tick_us, enable, uv_flag, delay_fast;
  logic ro_n, in_reset;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  por_reset_seq #(.BLANK_TICKS(BLANK), .SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) u_por_reset_seq (
    .clk(clk), .rst(rst), .tick_us(tick_us), .enable(enable),
    .uv_flag(uv_flag), .delay_fast(delay_fast), .ro_n(ro_n), .in_reset(in_reset)
  );

  function automatic int unsigned exp_delay(input logic fast);
    return fast ? FAST : SLOW;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic fast);
    enable = 1'b0;
    idle(2);
    delay_fast = fast;
    enable = 1'b1;
    idle(2);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    rst = 1'b1; tick_us = 1'b0; enable = 1'b0; uv_flag = 1'b0; delay_fast = 1'b0;
    idle(3);
    check("R1 ro_n in reset", ro_n, 1'b0);
    check("R2 in_reset in reset", in_reset, 1'b1);
    rst = 1'b0;
    idle(1);
    check("R1 ro_n after reset", ro_n, 1'b0);

    ticks(SLOW + 5);
    check("R3 disabled holds reset", ro_n, 1'b0);

    enable = 1'b1;
    idle(2);
    ticks(SLOW - 1);
    check("R4 slow delay not yet", ro_n, 1'b0);
    ticks(1);
    check("R4 slow delay released", ro_n, 1'b1);
    check("R2 in_reset released", in_reset, 1'b0);
    ticks(10);
    check("R10 stays released", ro_n, 1'b1);

    uv_flag = 1'b1;
    ticks(BLANK - 1);
    uv_flag = 1'b0;
    idle(2);
    check("R7 short glitch ignored", ro_n, 1'b1);

    uv_flag = 1'b1;
    ticks(BLANK - 1);
    check("R8 before blanking ends", ro_n, 1'b1);
    ticks(1);
    check("R8 reset after blanking", ro_n, 1'b0);
    uv_flag = 1'b0;
    delay_fast = 1'b1;
    idle(2);
    ticks(FAST - 1);
    check("R5 fast delay not yet", ro_n, 1'b0);
    ticks(1);
    check("R5 fast delay released", ro_n, 1'b1);

    enable = 1'b0;
    idle(1);
    check("R3 disable reacts next clock", ro_n, 1'b0);
    uv_flag = 1'b1;
    ticks(BLANK + 3);
    uv_flag = 1'b0;
    ticks(SLOW + 2);
    check("R3 held while disabled", ro_n, 1'b0);

    delay_fast = 1'b1; enable = 1'b1;
    idle(1);
    delay_fast = 1'b0;
    idle(1);
    ticks(FAST);
    check("R6 fast kept after strap change", ro_n, 1'b1);

    enable = 1'b0; idle(2);
    delay_fast = 1'b0; enable = 1'b1;
    idle(1);
    delay_fast = 1'b1;
    idle(1);
    ticks(FAST);
    check("R6 slow kept after strap change", ro_n, 1'b0);
    ticks(SLOW - FAST);
    check("R6 slow delay completes", ro_n, 1'b1);

    restart(1'b0);
    ticks(SLOW / 2);
    uv_flag = 1'b1;
    ticks(BLANK);
    uv_flag = 1'b0;
    idle(2);
    ticks(SLOW - 1);
    check("R9 full delay restarted", ro_n, 1'b0);
    ticks(1);
    check("R9 release after restart", ro_n, 1'b1);

    for (int it = 0; it < 30; it++) begin
      logic f;
      f = logic'($urandom_range(0, 1));
      restart(f);
      ticks(exp_delay(f) - 1);
      check("R4 R5 random delay not yet", ro_n, 1'b0);
      ticks(1);
      check("R4 R5 random delay released", ro_n, 1'b1);
      for (int g = 0; g < 3; g++) begin
        int len;
        len = int'($urandom_range(0, BLANK - 1));
        uv_flag = 1'b1;
        idle(1);
        ticks(len);
        uv_flag = 1'b0;
        idle(2);
        check("R7 random glitch ignored", ro_n, 1'b1);
        check("R2 random mirror", in_reset, !ro_n);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule